// File: doc/BRIEF.md
# Issue Queue Tag Wakeup Array

This block holds the waiting instructions of an out-of-order issue window and tracks when their source operands become available. Each slot stores a left and a right source tag, a ready flag for each of them and a valid flag. In every cycle a set of up to IW result tags is broadcast, each tag with its own valid bit. Every occupied slot compares both stored tags against all broadcast tags in parallel. A hit on either side latches that side's ready flag. The flag then stays set until the slot is written again.

A slot whose valid flag and both ready flags are set raises its bit in the request vector. An external selector reads this vector and answers with a one-hot or multi-hot grant vector. A granted slot is freed at the next clock edge. The allocator writes new instructions into a slot it names by index. A tag being broadcast in that same cycle is captured as already ready, so no wakeup is lost across allocation. The per-slot payload (tags, ready flags, valid) is exported for the downstream stages.

Top module: `iq_wakeup_array`

## Requirements
- R1: While rst_n is low, and after its release until the first allocation, every slot reads valid 0, both ready flags 0, both tags 0 and request 0.
- R2: With alloc_en high at a clock edge, slot alloc_idx takes alloc_tag_l, alloc_tag_r, alloc_rdy_l and alloc_rdy_r and reads valid 1 from the next cycle. Slot i occupies bits [i*TAG_W +: TAG_W] of the tag outputs and bit i of the flag vectors.
- R3: When a valid slot's stored tag equals any broadcast tag whose bc_valid bit is 1 (slot k in bc_tag[k*TAG_W +: TAG_W]), that side's ready flag reads 1 in the next cycle. Every broadcast slot is checked in the same cycle.
- R4: A broadcast slot whose bc_valid bit is 0 never sets a ready flag, even when its tag matches.
- R5: Once set, a ready flag of a valid slot stays set until the slot is allocated again.
- R6: req[i] is 1 exactly when slot i is valid and both of its ready flags are 1.
- R7: On allocation, a side whose new tag equals a valid broadcast tag in the same cycle is written as ready, whatever its alloc_rdy bit is.
- R8: A slot with its grant bit set reads valid 0 in the next cycle. An allocation to the same slot in the same cycle takes precedence and leaves it valid with the new contents.
- R9: Broadcasts do not change the ready flags of a slot whose valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en | input | 1 | Write a new instruction this cycle |
| alloc_idx | input | IDX_W | Slot to write |
| alloc_tag_l | input | TAG_W | Left source tag of the new instruction |
| alloc_tag_r | input | TAG_W | Right source tag of the new instruction |
| alloc_rdy_l | input | 1 | Left source already available |
| alloc_rdy_r | input | 1 | Right source already available |
| grant | input | ENTRIES | Slots chosen for issue, freed at the next edge |
| bc_valid | input | IW | Valid bit per broadcast slot |
| bc_tag | input | IW*TAG_W | Broadcast result tags, slot k at [k*TAG_W +: TAG_W] |
| req | output | ENTRIES | Per-slot issue request |
| ent_valid | output | ENTRIES | Per-slot occupied flag |
| ent_rdy_l | output | ENTRIES | Per-slot left ready flag |
| ent_rdy_r | output | ENTRIES | Per-slot right ready flag |
| ent_tag_l | output | ENTRIES*TAG_W | Per-slot left tag |
| ent_tag_r | output | ENTRIES*TAG_W | Per-slot right tag |

## Verification
The wakeup compare is driven with single hits on each broadcast slot in turn. It is then driven with both slots hitting different entries in one cycle, which separates the OR over broadcast slots from a single-port compare. Matching tags with their valid bits cleared tell a compare that honours slot validity from one that ignores it. Idle stretches show that ready flags stay set, and broadcasts aimed at empty slots show that unoccupied slots are left alone. Same-cycle allocation with a matching broadcast and grant colliding with allocation probe the two precedence cases. A long random phase with a narrow tag space then produces many coincident hits, frees and rewrites.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
  localparam int unsigned IQW_ENTRIES = 8;
  localparam int unsigned IQW_TAG_W   = 6;
  localparam int unsigned IQW_IW      = 2;

  typedef enum logic [1:0] {
    SLOT_HOLD = 2'd0,
    SLOT_LOAD = 2'd1,
    SLOT_FREE = 2'd2
  } slot_op_e;
endpackage

// File: rtl/iqw_tag_match.sv
module iqw_tag_match #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic [TAG_W-1:0]    tag,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  output logic                hit
);
  logic [IW-1:0] slot_hit;

  for (genvar k = 0; k < IW; k++) begin : g_slot
    assign slot_hit[k] = bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == tag);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/iqw_entry.sv
module iqw_entry
  import iqw_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic [TAG_W-1:0]    new_tag_l,
  input  logic [TAG_W-1:0]    new_tag_r,
  input  logic                new_rdy_l,
  input  logic                new_rdy_r,
  input  logic                gnt,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  output logic                valid,
  output logic                rdy_l,
  output logic                rdy_r,
  output logic [TAG_W-1:0]    tag_l,
  output logic [TAG_W-1:0]    tag_r
);
  logic             valid_q, valid_d;
  logic             rdy_l_q, rdy_l_d, rdy_r_q, rdy_r_d;
  logic [TAG_W-1:0] tag_l_q, tag_l_d, tag_r_q, tag_r_d;
  logic             hit_l, hit_r;
  logic             upd_en;
  slot_op_e         op;

  iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_l (
    .tag(tag_l_q), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_l)
  );
  iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_r (
    .tag(tag_r_q), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(hit_r)
  );

  always_comb begin
    if (sel)                op = SLOT_LOAD;
    else if (gnt & valid_q) op = SLOT_FREE;
    else                    op = SLOT_HOLD;
  end

  always_comb begin
    valid_d = valid_q;
    tag_l_d = tag_l_q;
    tag_r_d = tag_r_q;
    rdy_l_d = rdy_l_q | hit_l;
    rdy_r_d = rdy_r_q | hit_r;
    case (op)
      SLOT_LOAD: begin
        valid_d = 1'b1;
        tag_l_d = new_tag_l;
        tag_r_d = new_tag_r;
        rdy_l_d = new_rdy_l;
        rdy_r_d = new_rdy_r;
      end
      SLOT_FREE: valid_d = 1'b0;
      default:   ;
    endcase
  end

  // State moves only for an occupied slot or on a write.
  assign upd_en = sel | valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdy_l_q <= 1'b0;
      rdy_r_q <= 1'b0;
      tag_l_q <= '0;
      tag_r_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      rdy_l_q <= rdy_l_d;
      rdy_r_q <= rdy_r_d;
      tag_l_q <= tag_l_d;
      tag_r_q <= tag_r_d;
    end
  end

  assign valid = valid_q;
  assign rdy_l = rdy_l_q;
  assign rdy_r = rdy_r_q;
  assign tag_l = tag_l_q;
  assign tag_r = tag_r_q;
endmodule

// File: rtl/iq_wakeup_array.sv
module iq_wakeup_array
  import iqw_pkg::*;
#(
  parameter  int unsigned ENTRIES = IQW_ENTRIES,
  parameter  int unsigned TAG_W   = IQW_TAG_W,
  parameter  int unsigned IW      = IQW_IW,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic [TAG_W-1:0]         alloc_tag_l,
  input  logic [TAG_W-1:0]         alloc_tag_r,
  input  logic                     alloc_rdy_l,
  input  logic                     alloc_rdy_r,
  input  logic [ENTRIES-1:0]       grant,
  input  logic [IW-1:0]            bc_valid,
  input  logic [IW*TAG_W-1:0]      bc_tag,
  output logic [ENTRIES-1:0]       req,
  output logic [ENTRIES-1:0]       ent_valid,
  output logic [ENTRIES-1:0]       ent_rdy_l,
  output logic [ENTRIES-1:0]       ent_rdy_r,
  output logic [ENTRIES*TAG_W-1:0] ent_tag_l,
  output logic [ENTRIES*TAG_W-1:0] ent_tag_r
);
  logic new_hit_l, new_hit_r;
  logic wr_rdy_l, wr_rdy_r;
  logic [ENTRIES-1:0] sel;

  // One shared compare for the incoming tags serves every slot.
  iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_new_l (
    .tag(alloc_tag_l), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(new_hit_l)
  );
  iqw_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_new_r (
    .tag(alloc_tag_r), .bc_valid(bc_valid), .bc_tag(bc_tag), .hit(new_hit_r)
  );

  assign wr_rdy_l = alloc_rdy_l | new_hit_l;
  assign wr_rdy_r = alloc_rdy_r | new_hit_r;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign sel[i] = alloc_en && (alloc_idx == IDX_W'(i));

    iqw_entry #(.TAG_W(TAG_W), .IW(IW)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel[i]),
      .new_tag_l (alloc_tag_l),
      .new_tag_r (alloc_tag_r),
      .new_rdy_l (wr_rdy_l),
      .new_rdy_r (wr_rdy_r),
      .gnt       (grant[i]),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .valid     (ent_valid[i]),
      .rdy_l     (ent_rdy_l[i]),
      .rdy_r     (ent_rdy_r[i]),
      .tag_l     (ent_tag_l[i*TAG_W +: TAG_W]),
      .tag_r     (ent_tag_r[i*TAG_W +: TAG_W])
    );

    assign req[i] = ent_valid[i] & ent_rdy_l[i] & ent_rdy_r[i];
  end
endmodule

// File: rtl/iqw_checker.sv
module iqw_checker #(
  parameter  int unsigned ENTRIES = 8,
  parameter  int unsigned TAG_W   = 6,
  parameter  int unsigned IW      = 2,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     alloc_en,
  input logic [IDX_W-1:0]         alloc_idx,
  input logic [TAG_W-1:0]         alloc_tag_l,
  input logic [TAG_W-1:0]         alloc_tag_r,
  input logic                     alloc_rdy_l,
  input logic                     alloc_rdy_r,
  input logic [ENTRIES-1:0]       grant,
  input logic [IW-1:0]            bc_valid,
  input logic [IW*TAG_W-1:0]      bc_tag,
  input logic [ENTRIES-1:0]       req,
  input logic [ENTRIES-1:0]       ent_valid,
  input logic [ENTRIES-1:0]       ent_rdy_l,
  input logic [ENTRIES-1:0]       ent_rdy_r,
  input logic [ENTRIES*TAG_W-1:0] ent_tag_l,
  input logic [ENTRIES*TAG_W-1:0] ent_tag_r
);
  logic [ENTRIES-1:0] hl, hr, wr;
  logic al_hit_l, al_hit_r;

  always_comb begin
    al_hit_l = 1'b0;
    al_hit_r = 1'b0;
    for (int k = 0; k < IW; k++) begin
      if (bc_valid[k] && bc_tag[k*TAG_W +: TAG_W] == alloc_tag_l) al_hit_l = 1'b1;
      if (bc_valid[k] && bc_tag[k*TAG_W +: TAG_W] == alloc_tag_r) al_hit_r = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      hl[i] = 1'b0;
      hr[i] = 1'b0;
      wr[i] = alloc_en && (int'(alloc_idx) == i);
      for (int k = 0; k < IW; k++) begin
        if (bc_valid[k] && bc_tag[k*TAG_W +: TAG_W] == ent_tag_l[i*TAG_W +: TAG_W]) hl[i] = 1'b1;
        if (bc_valid[k] && bc_tag[k*TAG_W +: TAG_W] == ent_tag_r[i*TAG_W +: TAG_W]) hr[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    a_r3_wake_l: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] && !wr[i] && hl[i] |=> ent_rdy_l[i]);
    a_r3_wake_r: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] && !wr[i] && hr[i] |=> ent_rdy_r[i]);
    a_r4_no_false_l: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] && !ent_rdy_l[i] && !wr[i] && !hl[i] |=> !ent_rdy_l[i]);
    a_r5_sticky_l: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] && ent_rdy_l[i] && !wr[i] |=> ent_rdy_l[i]);
    a_r5_sticky_r: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] && ent_rdy_r[i] && !wr[i] |=> ent_rdy_r[i]);
    a_r6_req_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      req[i] |-> ent_valid[i] && ent_rdy_l[i] && ent_rdy_r[i]);
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      wr[i] && al_hit_l && al_hit_r |=> ent_rdy_l[i] && ent_rdy_r[i]);
    a_r8_free: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] && !wr[i] |=> !ent_valid[i]);
    a_r8_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr[i] |=> ent_valid[i]);
    a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_valid[i] && !wr[i] |=> $stable(ent_rdy_l[i]) && $stable(ent_rdy_r[i]));
  end
endmodule

bind iq_wakeup_array iqw_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IW(IW)) u_iqw_checker (.*);

// File: tb/test_iq_wakeup_array.sv
module test_iq_wakeup_array;
  localparam int ENTRIES = 8;
  localparam int TAG_W   = 6;
  localparam int IW      = 2;
  localparam int IDX_W   = 3;

  logic clk, rst_n;
  logic alloc_en;
  logic [IDX_W-1:0] alloc_idx;
  logic [TAG_W-1:0] alloc_tag_l, alloc_tag_r;
  logic alloc_rdy_l, alloc_rdy_r;
  logic [ENTRIES-1:0] grant;
  logic [IW-1:0] bc_valid;
  logic [IW*TAG_W-1:0] bc_tag;
  logic [ENTRIES-1:0] req, ent_valid, ent_rdy_l, ent_rdy_r;
  logic [ENTRIES*TAG_W-1:0] ent_tag_l, ent_tag_r;

  iq_wakeup_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IW(IW)) i_iq_wakeup_array (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_tag_l(alloc_tag_l), .alloc_tag_r(alloc_tag_r),
    .alloc_rdy_l(alloc_rdy_l), .alloc_rdy_r(alloc_rdy_r), .grant(grant),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .req(req), .ent_valid(ent_valid),
    .ent_rdy_l(ent_rdy_l), .ent_rdy_r(ent_rdy_r),
    .ent_tag_l(ent_tag_l), .ent_tag_r(ent_tag_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur = "R1";

  // Behavioural reference state
  bit m_v [ENTRIES];
  bit m_rl[ENTRIES];
  bit m_rr[ENTRIES];
  int m_tl[ENTRIES];
  int m_tr[ENTRIES];

  function automatic bit bc_hit(int t);
    for (int k = 0; k < IW; k++)
      if (bc_valid[k] && int'(bc_tag[k*TAG_W +: TAG_W]) == t) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        m_v[i] = 0; m_rl[i] = 0; m_rr[i] = 0; m_tl[i] = 0; m_tr[i] = 0;
      end
    end else begin
      bit hl[ENTRIES];
      bit hr[ENTRIES];
      bit nl, nr;
      nl = bc_hit(int'(alloc_tag_l));
      nr = bc_hit(int'(alloc_tag_r));
      for (int i = 0; i < ENTRIES; i++) begin
        hl[i] = bc_hit(m_tl[i]);
        hr[i] = bc_hit(m_tr[i]);
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_en && int'(alloc_idx) == i) begin
          m_v[i] = 1; m_tl[i] = int'(alloc_tag_l); m_tr[i] = int'(alloc_tag_r);
          m_rl[i] = alloc_rdy_l | nl; m_rr[i] = alloc_rdy_r | nr;
        end else if (m_v[i]) begin
          if (hl[i]) m_rl[i] = 1;
          if (hr[i]) m_rr[i] = 1;
          if (grant[i]) m_v[i] = 0;
        end
      end
    end
  end

  task automatic check_vec(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [ENTRIES-1:0] ev, erl, err, erq;
    logic [ENTRIES*TAG_W-1:0] etl, etr;
    for (int i = 0; i < ENTRIES; i++) begin
      ev[i] = m_v[i]; erl[i] = m_rl[i]; err[i] = m_rr[i];
      erq[i] = m_v[i] & m_rl[i] & m_rr[i];
      etl[i*TAG_W +: TAG_W] = TAG_W'(m_tl[i]);
      etr[i*TAG_W +: TAG_W] = TAG_W'(m_tr[i]);
    end
    check_vec("valid", 64'(ent_valid), 64'(ev));
    check_vec("rdy_l", 64'(ent_rdy_l), 64'(erl));
    check_vec("rdy_r", 64'(ent_rdy_r), 64'(err));
    check_vec("req",   64'(req),       64'(erq));
    check_vec("tag_l", 64'(ent_tag_l), 64'(etl));
    check_vec("tag_r", 64'(ent_tag_r), 64'(etr));
  endtask

  task automatic quiet();
    alloc_en = 0; alloc_idx = '0; alloc_tag_l = '0; alloc_tag_r = '0;
    alloc_rdy_l = 0; alloc_rdy_r = 0; grant = '0; bc_valid = '0; bc_tag = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    quiet();
  endtask

  task automatic alloc(int idx, int tl, int tr, bit rl, bit rr);
    alloc_en = 1; alloc_idx = IDX_W'(idx);
    alloc_tag_l = TAG_W'(tl); alloc_tag_r = TAG_W'(tr);
    alloc_rdy_l = rl; alloc_rdy_r = rr;
  endtask

  task automatic bcast(int k, bit v, int t);
    bc_valid[k] = v;
    bc_tag[k*TAG_W +: TAG_W] = TAG_W'(t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired in phase %s", cur);
    finish_run();
  end

  initial begin
    rst_n = 0;
    quiet();
    cur = "R1";
    repeat (3) begin
      @(negedge clk);
      check_vec("valid in reset", 64'(ent_valid), 64'd0);
      check_vec("req in reset", 64'(req), 64'd0);
      check_vec("rdy in reset", 64'({ent_rdy_l, ent_rdy_r}), 64'd0);
    end
    rst_n = 1;
    tick();

    cur = "R2";
    alloc(0, 1, 2, 0, 0); tick();
    alloc(1, 3, 4, 1, 0); tick();
    alloc(2, 5, 5, 0, 0); tick();
    alloc(3, 6, 7, 1, 1); tick();

    cur = "R6";
    tick();

    cur = "R3";
    bcast(0, 1, 1); tick();
    bcast(1, 1, 4); tick();
    bcast(0, 1, 2); bcast(1, 1, 5); tick();

    cur = "R4";
    alloc(4, 9, 10, 0, 0); tick();
    bcast(0, 0, 9); bcast(1, 0, 10); tick();

    cur = "R5";
    repeat (3) tick();

    cur = "R7";
    alloc(5, 11, 12, 0, 0); bcast(0, 1, 11); bcast(1, 1, 12); tick();
    alloc(6, 20, 21, 0, 1); bcast(1, 1, 20); tick();

    cur = "R8";
    grant = 8'b0000_0011; tick();
    grant = 8'b0000_0100; alloc(2, 13, 14, 0, 0); tick();
    tick();

    cur = "R9";
    bcast(0, 1, 0); bcast(1, 1, 3); tick();
    tick();

    cur = "R3";
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 1)
        alloc(int'($urandom_range(0, ENTRIES-1)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      for (int k = 0; k < IW; k++)
        bcast(k, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
      grant = ENTRIES'($urandom) & req;
      tick();
    end

    finish_run();
  end
endmodule